// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is a synchronous I2C slave that fronts a 256-byte register array. The system clock oversamples SCL and SDA. The block picks out start and stop conditions on the bus and receives bytes most significant bit first. It compares the select byte against three strap inputs. It acknowledges a byte or returns read data by pulling SDA low through an open-drain enable.

An 8-bit address counter serves all access types. A write select followed by an address byte loads the counter. Data bytes that follow are written into the array. A read select streams bytes out from the counter, and the counter advances after each byte.

A second device type drives a one-time guard. Writing to the guard type locks the lower half of the array against writes. From then on, the block no longer answers the guard type.

Top module: `i2cm_slave`

## Requirements
- R1: After reset the SDA pull-low output is released, every array byte reads FFh, the address counter is 00h and the guard is not set.
- R2: Bus activity is ignored until a start condition, which is SDA falling while SCL is high. A stop condition, which is SDA rising while SCL is high, returns the block to standby.
- R3: The select byte carries the device type in bits 7..4 (1010b for the array, 0110b for the guard), the strap comparison value in bits 3..1 (bit 3 = strap_i[2], bit 1 = strap_i[0]) and the direction in bit 0 (1 = read). On a match the block pulls SDA low in the 9th bit time. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R4: After an array write select, the next byte loads the address counter. Each following data byte is acknowledged and stored at the counter. Only counter bits 3..0 then increment, so writes wrap within a 16-byte page.
- R5: A read select without a preceding address byte returns the byte at the current counter and then increments the counter.
- R6: A write select and an address byte, followed by a repeated start and a read select, return the byte at the loaded address.
- R7: During a sequential read the counter advances after each byte and wraps from FFh to 00h.
- R8: If SDA is high in the 9th bit time after a read byte, the block stops driving and stays released until the next start.
- R9: A guard-type write select, any address byte and any data byte set a sticky guard. After that, guard-type selects get no acknowledge. Array data bytes aimed at 00h..7Fh get no acknowledge and are not stored. Addresses 80h..FFh and all reads are unaffected.
- R10: A read select with the guard device type is never acknowledged.
- R11: Read data leaves most significant bit first, and the pull-low enable only turns on while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| strap_i | input | 3 | Strap value compared with select bits 3..1 |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
A bus edge passes through two synchroniser flops and an edge-detect compare, and the pull-low register updates on the third system clock edge after SCL falls. An acknowledge or data bit is therefore valid about three cycles into the SCL low phase. Stored bytes take effect at the SCL rise that carries their last bit. The bench holds each SCL phase for ten or more clock cycles and reads SDA in the middle of the high phase, well after the pull has settled and well before it can change. Every protocol check is therefore made on a settled line rather than near an edge.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [3:0] DEV_ARRAY = 4'b1010;
  localparam logic [3:0] DEV_GUARD = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADR,
    ST_WR,
    ST_RD,
    ST_ACK,
    ST_MACK
  } phase_e;

  typedef enum logic {
    TGT_ARRAY,
    TGT_GUARD
  } target_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_s, sda_s;
  logic              scl_q, sda_q;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock_set,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/i2cm_proto.sv
module i2cm_proto
  import i2cm_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start,
  input  logic               stop,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               locked,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               wr_en,
  output logic [DATA_W-1:0]  wr_data,
  output logic               lock_set,
  output logic               rd_load,
  output phase_e             phase_o,
  output logic               sda_pull_o
);

  localparam int              CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

  phase_e              phase_q, phase_d;
  phase_e              nxt_q, nxt_d;
  target_e             tgt_q, tgt_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0]   shreg_q, shreg_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                half_q, half_d;
  logic                pull_q, pull_d;

  logic [DATA_W-1:0]   byte_in;
  logic [3:0]          sel_type;
  logic [STRAP_W-1:0]  sel_strap;
  logic                sel_rd;
  logic                byte_done;
  logic                guarded;
  logic                do_load;

  assign byte_in   = {shreg_q[DATA_W-2:0], sda_s};
  assign sel_type  = byte_in[DATA_W-1 -: 4];
  assign sel_strap = byte_in[STRAP_W:1];
  assign sel_rd    = byte_in[0];
  assign byte_done = scl_rise && (cnt_q == LAST_BIT);
  assign guarded   = locked && !addr_q[ADDR_W-1];

  always_comb begin
    phase_d  = phase_q;
    nxt_d    = nxt_q;
    tgt_d    = tgt_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    addr_d   = addr_q;
    half_d   = half_q;
    pull_d   = pull_q;
    wr_en    = 1'b0;
    lock_set = 1'b0;
    do_load  = 1'b0;

    if (stop) begin
      phase_d = ST_IDLE;
      pull_d  = 1'b0;
      half_d  = 1'b0;
    end else if (start) begin
      phase_d = ST_SEL;
      cnt_d   = '0;
      pull_d  = 1'b0;
      half_d  = 1'b0;
    end else begin
      case (phase_q)
        ST_SEL, ST_ADR, ST_WR: begin
          if (scl_rise) begin
            shreg_d = byte_in;
            cnt_d   = cnt_q + 1'b1;
          end
          if (byte_done) begin
            cnt_d   = '0;
            phase_d = ST_ACK;
            nxt_d   = ST_WR;
            if (phase_q == ST_SEL) begin
              if (sel_strap != strap) begin
                phase_d = ST_IDLE;
              end else if (sel_type == DEV_ARRAY) begin
                tgt_d = TGT_ARRAY;
                nxt_d = sel_rd ? ST_RD : ST_ADR;
              end else if (sel_type == DEV_GUARD && !locked && !sel_rd) begin
                tgt_d = TGT_GUARD;
                nxt_d = ST_ADR;
              end else begin
                phase_d = ST_IDLE;
              end
            end else if (phase_q == ST_ADR) begin
              if (tgt_q == TGT_ARRAY) addr_d = ADDR_W'(byte_in);
            end else begin
              if (tgt_q == TGT_GUARD) begin
                lock_set = 1'b1;
              end else if (guarded) begin
                phase_d = ST_IDLE;
              end else begin
                wr_en  = 1'b1;
                addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!half_q) begin
              pull_d = 1'b1;
              half_d = 1'b1;
            end else begin
              pull_d  = 1'b0;
              half_d  = 1'b0;
              cnt_d   = '0;
              phase_d = nxt_q;
              do_load = (nxt_q == ST_RD);
            end
          end
        end
        ST_RD: begin
          if (scl_rise) cnt_d = cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == ACK_SLOT) begin
              pull_d  = 1'b0;
              half_d  = 1'b0;
              phase_d = ST_MACK;
            end else begin
              pull_d  = ~shreg_q[DATA_W-2];
              shreg_d = shreg_q << 1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_s) phase_d = ST_IDLE;
            else       half_d  = 1'b1;
          end
          if (scl_fall && half_q) begin
            half_d  = 1'b0;
            do_load = 1'b1;
          end
        end
        default: begin
        end
      endcase
    end

    rd_load = do_load;
    if (do_load) begin
      phase_d = ST_RD;
      cnt_d   = '0;
      shreg_d = rd_data;
      pull_d  = ~rd_data[DATA_W-1];
      addr_d  = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      tgt_q   <= TGT_ARRAY;
      cnt_q   <= '0;
      shreg_q <= '0;
      addr_q  <= '0;
      half_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      nxt_q   <= nxt_d;
      tgt_q   <= tgt_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      addr_q  <= addr_d;
      half_q  <= half_d;
      pull_q  <= pull_d;
    end
  end

  assign addr_o     = addr_q;
  assign wr_data    = byte_in;
  assign phase_o    = phase_q;
  assign sda_pull_o = pull_q;

endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pull_o
);

  localparam int DATA_W = 8;

  logic              sda_w, rise_w, fall_w, start_w, stop_w;
  logic [ADDR_W-1:0] addr_w;
  logic              wr_en_w, lock_set_w, locked_w, rd_load_w;
  logic [DATA_W-1:0] wr_data_w, rd_data_w;
  phase_e            phase_w;

  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  i2cm_proto #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W),
    .STRAP_W(STRAP_W)
  ) u_proto (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_w),
    .scl_rise   (rise_w),
    .scl_fall   (fall_w),
    .start      (start_w),
    .stop       (stop_w),
    .strap      (strap_i),
    .rd_data    (rd_data_w),
    .locked     (locked_w),
    .addr_o     (addr_w),
    .wr_en      (wr_en_w),
    .wr_data    (wr_data_w),
    .lock_set   (lock_set_w),
    .rd_load    (rd_load_w),
    .phase_o    (phase_w),
    .sda_pull_o (sda_pull_o)
  );

  i2cm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_w),
    .wr_addr  (addr_w),
    .wr_data  (wr_data_w),
    .lock_set (lock_set_w),
    .rd_addr  (addr_w),
    .rd_data  (rd_data_w),
    .locked   (locked_w)
  );

endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input phase_e            phase,
  input logic              wr_en,
  input logic              lock_set,
  input logic              locked,
  input logic              rd_load,
  input logic [ADDR_W-1:0] addr
);

  a_r11_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  a_r2_standby_released: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE) |-> !sda_pull_o);

  a_r9_guard_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(locked && !addr[ADDR_W-1]));

  a_r9_guard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r5_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  a_r4_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, lock_set, rd_load}));

endmodule

bind i2cm_slave i2cm_slave_chk #(.ADDR_W(ADDR_W)) u_i2cm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .phase      (phase_w),
  .wr_en      (wr_en_w),
  .lock_set   (lock_set_w),
  .locked     (locked_w),
  .rd_load    (rd_load_w),
  .addr       (addr_w)
);

// File: tb/test_i2cm_slave.sv
module test_i2cm_slave;

  localparam int CLK_T = 10;
  localparam int QTR   = 10;
  localparam int WDOG  = 150000;

  localparam logic [7:0] SEL_WR  = 8'hAA;
  localparam logic [7:0] SEL_RD  = 8'hAB;
  localparam logic [7:0] GRD_WR  = 8'h6A;
  localparam logic [7:0] GRD_RD  = 8'h6B;
  localparam logic [7:0] BAD_STR = 8'hA4;
  localparam logic [7:0] BAD_TYP = 8'hBA;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       pull;
  logic       sda_line;

  int vecs = 0;
  int errs = 0;
  logic [7:0] rbuf [4];

  assign sda_line = sda_m & ~pull;

  always #(CLK_T / 2) clk = ~clk;

  i2cm_slave i_i2cm_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .sda_pull_o (pull)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b0; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic bit_io(input logic b, output logic got);
    sda_m = b; wq();
    scl = 1'b1; wq();
    got = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_io(b[i], g);
    bit_io(1'b1, g);
    ack = ~g;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, g);
      d[i] = g;
    end
    bit_io(~m_ack, g);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, input logic exp_ack, input string req);
    logic ack;
    bus_start();
    send_byte(SEL_WR, ack); check("R3 write select ack", ack, 1'b1);
    send_byte(a, ack);      check("R4 address ack", ack, 1'b1);
    send_byte(d, ack);      check(req, ack, exp_ack);
    bus_stop();
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(SEL_WR, ack); check("R6 write select ack", ack, 1'b1);
    send_byte(a, ack);      check("R6 address ack", ack, 1'b1);
    bus_start();
    send_byte(SEL_RD, ack); check("R6 read select ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      rbuf[i] = d;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 pull released after reset", pull, 1'b0);
  endtask

  task automatic t_quiet();
    logic g;
    logic any = 1'b0;
    scl = 1'b0; wq();
    for (int i = 7; i >= 0; i--) begin
      bit_io(SEL_RD[i], g);
      any |= pull;
    end
    bit_io(1'b1, g);
    check("R2 no ack without start", g, 1'b1);
    check("R2 no drive without start", any, 1'b0);
  endtask

  task automatic t_reset_content();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(SEL_RD, ack); check("R3 read select ack", ack, 1'b1);
    recv_byte(1'b0, d);     check("R1 erased byte at 00h", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_page_write();
    logic ack;
    bus_start();
    send_byte(SEL_WR, ack); check("R3 write select ack", ack, 1'b1);
    send_byte(8'h10, ack);  check("R4 address ack", ack, 1'b1);
    send_byte(8'h11, ack);  check("R4 data ack 0", ack, 1'b1);
    send_byte(8'h22, ack);  check("R4 data ack 1", ack, 1'b1);
    send_byte(8'h33, ack);  check("R4 data ack 2", ack, 1'b1);
    send_byte(8'h44, ack);  check("R4 data ack 3", ack, 1'b1);
    bus_stop();
  endtask

  task automatic t_random_read();
    rd_rand(8'h10, 3);
    check("R6 first byte", rbuf[0], 8'h11);
    check("R7 R11 second byte", rbuf[1], 8'h22);
    check("R7 R11 third byte", rbuf[2], 8'h33);
  endtask

  task automatic t_current_read();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(SEL_RD, ack); check("R5 select ack", ack, 1'b1);
    recv_byte(1'b0, d);     check("R5 byte at counter 13h", d, 8'h44);
    bus_stop();
    bus_start();
    send_byte(SEL_RD, ack); check("R5 select ack again", ack, 1'b1);
    recv_byte(1'b0, d);     check("R5 counter advanced to 14h", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_page_wrap();
    logic ack;
    bus_start();
    send_byte(SEL_WR, ack); check("R3 select ack", ack, 1'b1);
    send_byte(8'h2E, ack);  check("R4 address ack", ack, 1'b1);
    send_byte(8'hA1, ack);  check("R4 data ack 2Eh", ack, 1'b1);
    send_byte(8'hB2, ack);  check("R4 data ack 2Fh", ack, 1'b1);
    send_byte(8'hC3, ack);  check("R4 data ack wrapped", ack, 1'b1);
    bus_stop();
    rd_rand(8'h20, 1);
    check("R4 page wrap landed at 20h", rbuf[0], 8'hC3);
    rd_rand(8'h2E, 2);
    check("R4 byte at 2Eh", rbuf[0], 8'hA1);
    check("R4 byte at 2Fh", rbuf[1], 8'hB2);
    rd_rand(8'h30, 1);
    check("R4 next page untouched", rbuf[0], 8'hFF);
  endtask

  task automatic t_read_wrap();
    wr1(8'hFE, 8'h5A, 1'b1, "R7 data ack FEh");
    wr1(8'hFF, 8'h6B, 1'b1, "R7 data ack FFh");
    wr1(8'h00, 8'h7C, 1'b1, "R7 data ack 00h");
    rd_rand(8'hFE, 3);
    check("R7 byte FEh", rbuf[0], 8'h5A);
    check("R7 byte FFh", rbuf[1], 8'h6B);
    check("R7 wrapped to 00h", rbuf[2], 8'h7C);
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    send_byte(BAD_STR, ack); check("R3 strap mismatch no ack", ack, 1'b0);
    send_byte(8'h00, ack);   check("R3 standby after mismatch", ack, 1'b0);
    bus_stop();
    bus_start();
    send_byte(BAD_TYP, ack); check("R3 unknown type no ack", ack, 1'b0);
    bus_stop();
  endtask

  task automatic t_nack_standby();
    logic ack, g;
    logic [7:0] d;
    logic all_hi = 1'b1;
    bus_start();
    send_byte(SEL_WR, ack); check("R6 select ack", ack, 1'b1);
    send_byte(8'h10, ack);  check("R6 address ack", ack, 1'b1);
    bus_start();
    send_byte(SEL_RD, ack); check("R6 read select ack", ack, 1'b1);
    recv_byte(1'b0, d);     check("R8 byte before nack", d, 8'h11);
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, g);
      all_hi &= g;
    end
    check("R8 released after master nack", all_hi, 1'b1);
    bus_stop();
  endtask

  task automatic t_guard();
    logic ack;
    bus_start();
    send_byte(GRD_RD, ack); check("R10 guard read select no ack", ack, 1'b0);
    bus_stop();
    wr1(8'h05, 8'h55, 1'b1, "R9 lower write before guard");
    bus_start();
    send_byte(GRD_WR, ack); check("R9 guard select ack", ack, 1'b1);
    send_byte(8'h3C, ack);  check("R9 guard address ack", ack, 1'b1);
    send_byte(8'hC3, ack);  check("R9 guard data ack", ack, 1'b1);
    bus_stop();
    bus_start();
    send_byte(GRD_WR, ack); check("R9 guard type ignored once set", ack, 1'b0);
    bus_stop();
    wr1(8'h05, 8'h99, 1'b0, "R9 lower write refused");
    rd_rand(8'h05, 1);
    check("R9 lower byte kept", rbuf[0], 8'h55);
    wr1(8'h85, 8'h77, 1'b1, "R9 upper write accepted");
    rd_rand(8'h85, 1);
    check("R9 upper byte stored", rbuf[0], 8'h77);
    rd_rand(8'h10, 1);
    check("R9 reads unaffected", rbuf[0], 8'h11);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    wq();
    t_reset();
    t_quiet();
    t_reset_content();
    t_page_write();
    t_random_read();
    t_current_read();
    t_page_wrap();
    t_read_wrap();
    t_mismatch();
    t_nack_standby();
    t_guard();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule